// File: doc/BRIEF.md
# Master-Clock to Frame-Clock Ratio Detector

This block measures how many master-clock cycles fit between two successive rising edges of an already synchronised frame clock. It then matches the measured period against a fixed, irregular set of fourteen supported ratios. The clocking logic that follows it can then pick its dividers without any register programming. The result is reported only after the same ratio has been seen on several frames in a row, so a single glitched frame neither produces nor breaks a lock.

The block runs entirely in the master-clock domain. A configuration-mode input puts it aside when register settings take over from automatic detection. While that input is high, every output stays idle and all measurement state is cleared. When it goes low again, detection starts from scratch. A counter that saturates reports a frame clock that has stopped.

Top module: `mclk_ratio_detect`

## Requirements
- R1: The period is the number of master-clock cycles between two successive frame-clock rising edges. The first rising edge after reset, after configuration mode or after a saturation event only starts a measurement and yields no result.
- R2: A measured period is matched when it lies within ±1 cycle of a supported ratio. The match code is the ratio's position in the ascending list 32, 64, 96, 128, 192, 256, 384, 512, 640, 768, 1024, 1152, 1280, 1536, coded 0 to 13. The code output is 4 bits wide.
- R3: A period that matches no supported ratio, for example one that is 2 or more cycles from every entry, sets the unsupported flag.
- R4: Lock is asserted on the third consecutive measurement that yields the same supported code. The code output then shows that code and holds it for as long as lock lasts.
- R5: While not locked, the code output reads 15.
- R6: While locked, one measurement that differs from the locked code leaves the lock in place, and a matching measurement clears that miss. A second consecutive differing measurement drops the lock. That second measurement then becomes the first of a new lock attempt.
- R7: The period counter saturates at 2047. Reaching it without a rising edge drops the lock, forces code 15 and sets the unsupported flag.
- R8: While the configuration-mode input is high, the outputs read unlocked, code 15 and unsupported low, and measurement state is cleared. After the input falls, lock again needs a starting edge plus three matching measurements.
- R9: After reset the outputs read unlocked, code 15 and unsupported low.
- R10: The unsupported flag follows the latest measurement. The next supported measurement clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock; the counting clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lrck_sync_i | input | 1 | Frame clock, already synchronised to mclk_i |
| sw_cfg_mode_i | input | 1 | High: register configuration in effect, detection idle |
| ratio_code_o | output | 4 | Locked ratio code 0..13, or 15 |
| ratio_locked_o | output | 1 | Detected ratio is stable and valid |
| ratio_unsupported_o | output | 1 | Latest period matched no supported ratio, or the frame clock stopped |

## Verification
The assertions assume that the frame clock arrives already synchronised to the master clock, so each of its levels holds for at least one full master-clock cycle. The stimulus changes it only on the falling master-clock edge. The stimulus keeps a constant high time of eight cycles and varies only the low time. Every measured period is therefore exactly the requested one, which lets the bench sweep each supported ratio at offsets of −1, 0, +1 and ±2, plus several unsupported values. Configuration mode is entered only from a clean state between sweeps. A separate run stops the frame clock for longer than the counter range.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

    localparam int N_RATIOS  = 14;
    localparam int CODE_W    = 4;
    localparam logic [CODE_W-1:0] CODE_NONE = '1;

    // Supported master-clock cycles per frame, ascending; position = code.
    function automatic int ratio_of(input int idx);
        case (idx)
            0:       ratio_of = 32;
            1:       ratio_of = 64;
            2:       ratio_of = 96;
            3:       ratio_of = 128;
            4:       ratio_of = 192;
            5:       ratio_of = 256;
            6:       ratio_of = 384;
            7:       ratio_of = 512;
            8:       ratio_of = 640;
            9:       ratio_of = 768;
            10:      ratio_of = 1024;
            11:      ratio_of = 1152;
            12:      ratio_of = 1280;
            13:      ratio_of = 1536;
            default: ratio_of = 0;
        endcase
    endfunction

endpackage

// File: rtl/mrd_period_counter.sv
module mrd_period_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             lrck_i,
    output logic             meas_valid_o,
    output logic [CNT_W-1:0] meas_cnt_o,
    output logic             sat_o
);

    localparam logic [CNT_W-1:0] CNT_SAT = '1;
    localparam logic [CNT_W-1:0] CNT_PRE = CNT_SAT - 1'b1;

    typedef struct packed {
        logic             lrck;
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       rise;
    logic       at_limit;

    always_comb begin
        st_d         = st_q;
        st_d.lrck    = lrck_i;
        rise         = lrck_i & ~st_q.lrck;
        at_limit     = (st_q.cnt == CNT_SAT);
        meas_valid_o = 1'b0;
        sat_o        = 1'b0;

        if (clear_i) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
        end else if (rise) begin
            // R1: an unarmed edge only opens the first window
            meas_valid_o = st_q.armed & ~at_limit;
            st_d.cnt     = {{(CNT_W-1){1'b0}}, 1'b1};
            st_d.armed   = 1'b1;
        end else if (!at_limit) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_PRE) begin
                // R7: frame clock missing for the full counter range
                sat_o      = 1'b1;
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.lrck  <= 1'b1;
            st_q.armed <= 1'b0;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign meas_cnt_o = st_q.cnt;

endmodule

// File: rtl/mrd_ratio_match.sv
module mrd_ratio_match #(
    parameter int CNT_W = 11,
    parameter int TOL   = 1
) (
    input  logic [CNT_W-1:0]             cnt_i,
    output logic [mrd_pkg::CODE_W-1:0]   code_o
);

    localparam int N = mrd_pkg::N_RATIOS;

    logic [N-1:0] hit;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        localparam int RATIO = mrd_pkg::ratio_of(g);
        always_comb begin
            hit[g] = ((int'(cnt_i) + TOL) >= RATIO) && (int'(cnt_i) <= (RATIO + TOL));
        end
    end

    always_comb begin
        code_o = mrd_pkg::CODE_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) begin
                code_o = mrd_pkg::CODE_W'(i);
            end
        end
    end

endmodule

// File: rtl/mrd_lock_track.sv
module mrd_lock_track #(
    parameter int LOCK_FRAMES = 3,
    parameter int UNLOCK_MISS = 2
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        clear_i,
    input  logic                        meas_valid_i,
    input  logic [mrd_pkg::CODE_W-1:0]  code_i,
    input  logic                        sat_i,
    output logic [mrd_pkg::CODE_W-1:0]  ratio_idx_o,
    output logic                        locked_o,
    output logic                        unsupported_o
);

    localparam int CW       = mrd_pkg::CODE_W;
    localparam int STREAK_W = $clog2(LOCK_FRAMES + 1);
    localparam int MISS_W   = $clog2(UNLOCK_MISS + 1);

    typedef struct packed {
        logic                locked;
        logic [CW-1:0]       idx;
        logic [CW-1:0]       cand;
        logic [STREAK_W-1:0] streak;
        logic [MISS_W-1:0]   miss;
        logic                unsup;
    } lock_state_t;

    localparam lock_state_t IDLE = '{
        locked: 1'b0,
        idx:    mrd_pkg::CODE_NONE,
        cand:   mrd_pkg::CODE_NONE,
        streak: '0,
        miss:   '0,
        unsup:  1'b0
    };

    lock_state_t st_d, st_q;
    logic        code_ok;
    int          n_streak;
    int          n_miss;

    always_comb begin
        st_d     = st_q;
        code_ok  = (code_i != mrd_pkg::CODE_NONE);
        n_streak = (code_i == st_q.cand) ? int'(st_q.streak) + 1 : 1;
        n_miss   = int'(st_q.miss) + 1;

        if (clear_i) begin
            st_d = IDLE;                                 // R8
        end else if (sat_i) begin
            st_d       = IDLE;                           // R7
            st_d.unsup = 1'b1;
        end else if (meas_valid_i) begin
            st_d.unsup = ~code_ok;                       // R3, R10
            if (st_q.locked) begin
                if (code_i == st_q.idx) begin
                    st_d.miss = '0;
                end else if (n_miss >= UNLOCK_MISS) begin
                    // R6: drop lock and seed a new attempt
                    st_d.locked = 1'b0;
                    st_d.idx    = mrd_pkg::CODE_NONE;
                    st_d.miss   = '0;
                    st_d.cand   = code_i;
                    st_d.streak = code_ok ? STREAK_W'(1) : '0;
                end else begin
                    st_d.miss = MISS_W'(n_miss);
                end
            end else if (!code_ok) begin
                st_d.cand   = mrd_pkg::CODE_NONE;
                st_d.streak = '0;
            end else if (n_streak >= LOCK_FRAMES) begin
                // R4
                st_d.locked = 1'b1;
                st_d.idx    = code_i;
                st_d.cand   = code_i;
                st_d.streak = '0;
                st_d.miss   = '0;
            end else begin
                st_d.cand   = code_i;
                st_d.streak = STREAK_W'(n_streak);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ratio_idx_o   = st_q.idx;
    assign locked_o      = st_q.locked;
    assign unsupported_o = st_q.unsup;

endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect #(
    parameter int CNT_W       = 11,
    parameter int MATCH_TOL   = 1,
    parameter int LOCK_FRAMES = 3,
    parameter int UNLOCK_MISS = 2
) (
    input  logic                       mclk_i,
    input  logic                       rst_ni,
    input  logic                       lrck_sync_i,
    input  logic                       sw_cfg_mode_i,
    output logic [mrd_pkg::CODE_W-1:0] ratio_code_o,
    output logic                       ratio_locked_o,
    output logic                       ratio_unsupported_o
);

    logic                       meas_valid;
    logic [CNT_W-1:0]           meas_cnt;
    logic                       sat_evt;
    logic [mrd_pkg::CODE_W-1:0] meas_code;

    mrd_period_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk_i        (mclk_i),
        .rst_ni       (rst_ni),
        .clear_i      (sw_cfg_mode_i),
        .lrck_i       (lrck_sync_i),
        .meas_valid_o (meas_valid),
        .meas_cnt_o   (meas_cnt),
        .sat_o        (sat_evt)
    );

    mrd_ratio_match #(
        .CNT_W (CNT_W),
        .TOL   (MATCH_TOL)
    ) u_match (
        .cnt_i  (meas_cnt),
        .code_o (meas_code)
    );

    mrd_lock_track #(
        .LOCK_FRAMES (LOCK_FRAMES),
        .UNLOCK_MISS (UNLOCK_MISS)
    ) u_lock (
        .clk_i         (mclk_i),
        .rst_ni        (rst_ni),
        .clear_i       (sw_cfg_mode_i),
        .meas_valid_i  (meas_valid),
        .code_i        (meas_code),
        .sat_i         (sat_evt),
        .ratio_idx_o   (ratio_code_o),
        .locked_o      (ratio_locked_o),
        .unsupported_o (ratio_unsupported_o)
    );

endmodule

// File: rtl/mclk_ratio_detect_chk.sv
module mclk_ratio_detect_chk (
    input logic       mclk_i,
    input logic       rst_ni,
    input logic       lrck_sync_i,
    input logic       sw_cfg_mode_i,
    input logic [3:0] ratio_code_o,
    input logic       ratio_locked_o,
    input logic       ratio_unsupported_o
);

    logic lrck_prev_q;
    logic edge_seen;

    always_ff @(posedge mclk_i or negedge rst_ni) begin
        if (!rst_ni) lrck_prev_q <= 1'b1;
        else         lrck_prev_q <= lrck_sync_i;
    end

    assign edge_seen = lrck_sync_i & ~lrck_prev_q;

    assert_code_in_list_R2: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        ratio_locked_o |-> (ratio_code_o <= 4'd13));

    assert_idle_code_R5: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        !ratio_locked_o |-> (ratio_code_o == 4'd15));

    assert_code_held_R4: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        (ratio_locked_o && $past(ratio_locked_o)) |-> $stable(ratio_code_o));

    assert_lock_on_edge_R1: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        $rose(ratio_locked_o) |-> $past(edge_seen && !sw_cfg_mode_i));

    assert_cfg_mode_idle_R8: assert property (@(posedge mclk_i) disable iff (!rst_ni)
        sw_cfg_mode_i |=> (!ratio_locked_o && ratio_code_o == 4'd15 && !ratio_unsupported_o));

endmodule

bind mclk_ratio_detect mclk_ratio_detect_chk u_chk (
    .mclk_i              (mclk_i),
    .rst_ni              (rst_ni),
    .lrck_sync_i         (lrck_sync_i),
    .sw_cfg_mode_i       (sw_cfg_mode_i),
    .ratio_code_o        (ratio_code_o),
    .ratio_locked_o      (ratio_locked_o),
    .ratio_unsupported_o (ratio_unsupported_o)
);

// File: tb/mclk_ratio_detect_bench.sv
module mclk_ratio_detect_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HIGH_TIME  = 8;
    localparam int WDOG_LIMIT = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lrck = 1'b0;
    logic       sw_mode = 1'b0;
    logic [3:0] code;
    logic       locked;
    logic       unsup;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mclk_ratio_detect u_mclk_ratio_detect (
        .mclk_i              (clk),
        .rst_ni              (rst_n),
        .lrck_sync_i         (lrck),
        .sw_cfg_mode_i       (sw_mode),
        .ratio_code_o        (code),
        .ratio_locked_o      (locked),
        .ratio_unsupported_o (unsup)
    );

    function automatic int ratio_at(input int i);
        int r;
        case (i)
            0: r = 32;    1: r = 64;    2: r = 96;    3: r = 128;
            4: r = 192;   5: r = 256;   6: r = 384;   7: r = 512;
            8: r = 640;   9: r = 768;   10: r = 1024; 11: r = 1152;
            12: r = 1280; default: r = 1536;
        endcase
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_out(input string req, input int e_code, input bit e_lock, input bit e_unsup);
        chk(code == 4'(e_code), {req, " code"}, int'(code), e_code);
        chk(locked == e_lock, {req, " locked"}, int'(locked), int'(e_lock));
        chk(unsup == e_unsup, {req, " unsupported"}, int'(unsup), int'(e_unsup));
    endtask

    // each frame: low for (p - HIGH_TIME) cycles, then high; rise spacing = p
    task automatic frames(input int p, input int n);
        for (int k = 0; k < n; k++) begin
            lrck = 1'b0;
            repeat (p - HIGH_TIME) @(negedge clk);
            lrck = 1'b1;
            repeat (HIGH_TIME) @(negedge clk);
        end
        lrck = 1'b0;
    endtask

    task automatic restart();
        @(negedge clk);
        sw_mode = 1'b1;
        repeat (2) @(negedge clk);
        sw_mode = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == WDOG_LIMIT && !done) begin
            fails++;
            $display("FAIL R1..all watchdog actual=%0d expected<%0d", cycles, WDOG_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R9 reset", 15, 1'b0, 1'b0);

        // R2/R4/R1: every supported ratio at offsets -1, 0, +1
        for (int i = 0; i < 14; i++) begin
            for (int off = -1; off <= 1; off++) begin
                restart();
                frames(ratio_at(i) + off, 3);
                if (off == 0) expect_out("R1 R4 before third match", 15, 1'b0, 1'b0);
                frames(ratio_at(i) + off, 1);
                expect_out("R2 R4 locked code", i, 1'b1, 1'b0);
            end
        end

        // R3/R10: two cycles off is unsupported; next good frame clears flag
        for (int i = 0; i < 14; i++) begin
            restart();
            frames(ratio_at(i) + ((i % 2 == 0) ? 2 : -2), 3);
            expect_out("R3 off by two", 15, 1'b0, 1'b1);
            frames(ratio_at(i), 1);
            chk(unsup == 1'b0, "R10 flag cleared", int'(unsup), 0);
        end

        // R3: values far from any entry
        for (int v = 0; v < 3; v++) begin
            int p;
            p = (v == 0) ? 100 : (v == 1) ? 1000 : 2000;
            restart();
            frames(p, 3);
            expect_out("R3 foreign period", 15, 1'b0, 1'b1);
        end

        // R6: single miss tolerated, two consecutive drop the lock
        restart();
        frames(256, 4);
        expect_out("R6 initial lock", 5, 1'b1, 1'b0);
        frames(384, 1);
        expect_out("R6 one miss holds", 5, 1'b1, 1'b0);
        frames(256, 1);
        frames(384, 1);
        expect_out("R6 miss count cleared", 5, 1'b1, 1'b0);
        frames(384, 1);
        expect_out("R6 second miss drops", 15, 1'b0, 1'b0);
        frames(384, 2);
        expect_out("R6 relock on new ratio", 6, 1'b1, 1'b0);

        // R7: missing frame clock saturates the counter
        restart();
        frames(512, 4);
        expect_out("R7 lock before stop", 7, 1'b1, 1'b0);
        lrck = 1'b0;
        repeat (2100) @(negedge clk);
        expect_out("R7 saturated", 15, 1'b0, 1'b1);
        frames(512, 3);
        chk(locked == 1'b0, "R7 R1 restart needs edge", int'(locked), 0);
        frames(512, 1);
        expect_out("R7 relock after stop", 7, 1'b1, 1'b0);

        // R8: configuration mode holds outputs idle
        @(negedge clk);
        sw_mode = 1'b1;
        frames(256, 6);
        expect_out("R8 cfg mode idle", 15, 1'b0, 1'b0);
        sw_mode = 1'b0;
        frames(256, 3);
        chk(locked == 1'b0, "R8 restart not yet locked", int'(locked), 0);
        frames(256, 1);
        expect_out("R8 restart locks", 5, 1'b1, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule